// File: doc/BRIEF.md
# Audio Serial Clock Generator with Odd-Ratio Prescaler

This block derives the clocks for an audio serial port from a single source clock. A prescaler divides the source clock by a programmable ratio. The ratio is twice an 8-bit divide value, plus one when an odd-adjust bit is set. The prescaler output can be driven out as a master clock. In that case the bit clock is a further binary division of it, chosen so that the master clock always runs at 256 times the sample rate. With the master clock turned off, the prescaler output is the bit clock itself.

A sample frame holds a left channel and a right channel, each 16 or 32 bit clocks long. The word-select output is low for the left channel and high for the right one. In master mode the block drives the bit clock and word select. In slave mode both stay low, and only the master clock is still available.

Settings arrive over a write strobe with its data fields. A write is parked in a holding register. It takes effect at the next frame start, where word select returns to the left channel, so a frame is never cut short or stretched part-way through.

Top module: `audio_clkgen`

## Requirements
- R1: While reset is asserted, mck_o, bck_o and ws_o are low. After reset the active settings are divide 2, odd 0, master clock off and 16-bit channels.
- R2: The prescaler period is 2*DIV+ODD source cycles. Within each period the output is low for DIV cycles and then high for DIV+ODD cycles, so an odd ratio gives a high phase one cycle longer than the low phase.
- R3: With the master clock disabled (cfg_mck_en_i=0), bck_o equals the prescaler output and mck_o stays low.
- R4: With the master clock enabled, mck_o is the prescaler output. bck_o is mck_o divided by 4 for 32-bit channels (cfg_ch32_i=1) and by 8 for 16-bit channels (cfg_ch32_i=0), with equal low and high phases. Each bck_o falling edge coincides with a mck_o falling edge.
- R5: Each channel lasts 16 bit clocks (cfg_ch32_i=0) or 32 bit clocks (cfg_ch32_i=1). ws_o is 0 for the left channel and 1 for the right channel. ws_o changes only in the cycle where bck_o falls, and every bit period starts with bck_o falling.
- R6: A legal settings write is held. It becomes active at the next frame start (ws_o falling to 0). Bit clocks already under way keep the old timing until then.
- R7: A write with a divide value below 2 is ignored entirely: the pending and active settings are unchanged.
- R8: When master_i is low, bck_o and ws_o are held low from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1 = drive bit clock and word select, 0 = slave (held low) |
| cfg_we_i | input | 1 | Settings write strobe, one cycle |
| cfg_div_i | input | 8 | Divide value, legal range 2..255 |
| cfg_odd_i | input | 1 | Adds one source cycle to the ratio |
| cfg_mck_en_i | input | 1 | 1 = master clock output enabled |
| cfg_ch32_i | input | 1 | 1 = 32-bit channels, 0 = 16-bit channels |
| mck_o | output | 1 | Master clock |
| bck_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select, 0 = left, 1 = right |

## Verification
The bench builds the block with its default parameters: an 8-bit divide field, master-to-bit ratios of 4 and 8, and channel lengths of 16 and 32. Small divide values keep every frame within about 1,500 source cycles, so each of the four combinations of channel length and master-clock enable can be measured over a whole left channel. Odd and even ratios are both used, so the unequal high phase shows at both the master-clock and bit-clock level. The mid-frame hold, the rejected divide value and the slave gating are then reached with short directed runs.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;
  localparam int unsigned ACG_DIV_W = 8;

  typedef struct packed {
    logic [ACG_DIV_W-1:0] div;
    logic                 odd;
    logic                 mck_en;
    logic                 ch32;
  } acg_cfg_t;
endpackage

// File: rtl/acg_cfg_hold.sv
module acg_cfg_hold
  import audio_clkgen_pkg::*;
#(
  parameter int unsigned DIV_MIN = 2,
  parameter int unsigned DIV_RST = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  acg_cfg_t wr_cfg_i,
  input  logic     frame_end_i,
  output acg_cfg_t act_o
);
  localparam int unsigned W = ACG_DIV_W;
  localparam acg_cfg_t RST_CFG = '{div: W'(DIV_RST), odd: 1'b0, mck_en: 1'b0, ch32: 1'b0};

  acg_cfg_t act_q, act_n, pend_q, pend_n;
  logic     pv_q, pv_n;
  logic     legal;

  assign legal = (wr_cfg_i.div >= W'(DIV_MIN));

  always_comb begin
    act_n  = act_q;
    pend_n = pend_q;
    pv_n   = pv_q;
    if (we_i && legal) begin
      pend_n = wr_cfg_i;
      pv_n   = 1'b1;
    end
    if (frame_end_i) begin
      if (pv_n) act_n = pend_n;
      pv_n = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= RST_CFG;
      pend_q <= RST_CFG;
      pv_q   <= 1'b0;
    end else begin
      act_q  <= act_n;
      pend_q <= pend_n;
      pv_q   <= pv_n;
    end
  end

  assign act_o = act_q;

  // R7: an out-of-range divide value never becomes active
  assert_div_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q.div >= W'(DIV_MIN));

  // R6: active settings only move at a frame boundary
  assert_hold_until_frame_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> $stable(act_q));
endmodule

// File: rtl/acg_prescaler.sv
module acg_prescaler #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             odd_i,
  output logic             wrap_o,
  output logic             hi_nxt_o
);
  localparam int unsigned CW = DIV_W + 1;

  logic [CW-1:0] cnt_q, cnt_n, last;

  assign last   = {div_i, 1'b0} + CW'(odd_i) - CW'(1);
  assign wrap_o = (cnt_q == last);

  always_comb begin
    cnt_n    = wrap_o ? '0 : cnt_q + CW'(1);
    hi_nxt_o = (cnt_n >= {1'b0, div_i});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_n;
  end

  // R2: the phase counter never leaves the 2*DIV+ODD window
  assert_cnt_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last);
endmodule

// File: rtl/acg_frame_seq.sv
module acg_frame_seq #(
  parameter int unsigned MCK_R_WIDE   = 4,
  parameter int unsigned MCK_R_NARROW = 8,
  parameter int unsigned CH_WIDE      = 32,
  parameter int unsigned CH_NARROW    = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  input  logic pre_hi_nxt_i,
  input  logic mck_en_i,
  input  logic ch32_i,
  output logic bck_nxt_o,
  output logic ws_nxt_o,
  output logic frame_end_o
);
  localparam int unsigned SW = $clog2(MCK_R_NARROW) + 1;
  localparam int unsigned BW = $clog2(2 * CH_WIDE) + 1;

  logic [SW-1:0] sub_q, sub_n, ratio;
  logic [BW-1:0] bit_q, bit_n, flen;
  logic          sub_last, per_end, bit_last;

  always_comb begin
    ratio = mck_en_i ? (ch32_i ? SW'(MCK_R_WIDE) : SW'(MCK_R_NARROW)) : SW'(1);
    flen  = ch32_i ? BW'(2 * CH_WIDE) : BW'(2 * CH_NARROW);

    sub_last    = (sub_q == ratio - SW'(1));
    per_end     = wrap_i && sub_last;
    bit_last    = (bit_q == flen - BW'(1));
    frame_end_o = per_end && bit_last;

    sub_n = wrap_i ? (sub_last ? '0 : sub_q + SW'(1)) : sub_q;
    bit_n = per_end ? (bit_last ? '0 : bit_q + BW'(1)) : bit_q;

    bck_nxt_o = mck_en_i ? (sub_n >= (ratio >> 1)) : pre_hi_nxt_i;
    ws_nxt_o  = (bit_n >= (flen >> 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0;
      bit_q <= '0;
    end else begin
      sub_q <= sub_n;
      bit_q <= bit_n;
    end
  end

  // R5: bit index stays inside the frame for the active channel length
  assert_bit_in_frame_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q < flen);
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import audio_clkgen_pkg::*;
#(
  parameter int unsigned DIV_MIN      = 2,
  parameter int unsigned DIV_RST      = 2,
  parameter int unsigned MCK_R_WIDE   = 4,
  parameter int unsigned MCK_R_NARROW = 8,
  parameter int unsigned CH_WIDE      = 32,
  parameter int unsigned CH_NARROW    = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 master_i,
  input  logic                 cfg_we_i,
  input  logic [ACG_DIV_W-1:0] cfg_div_i,
  input  logic                 cfg_odd_i,
  input  logic                 cfg_mck_en_i,
  input  logic                 cfg_ch32_i,
  output logic                 mck_o,
  output logic                 bck_o,
  output logic                 ws_o
);
  acg_cfg_t wr_cfg, act;
  logic     wrap, pre_hi_nxt, bck_nxt, ws_nxt, frame_end;
  logic     mck_q, bck_q, ws_q;

  assign wr_cfg = '{div: cfg_div_i, odd: cfg_odd_i, mck_en: cfg_mck_en_i, ch32: cfg_ch32_i};

  acg_cfg_hold #(.DIV_MIN(DIV_MIN), .DIV_RST(DIV_RST)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .wr_cfg_i(wr_cfg),
    .frame_end_i(frame_end), .act_o(act)
  );

  acg_prescaler #(.DIV_W(ACG_DIV_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(act.div), .odd_i(act.odd),
    .wrap_o(wrap), .hi_nxt_o(pre_hi_nxt)
  );

  acg_frame_seq #(
    .MCK_R_WIDE(MCK_R_WIDE), .MCK_R_NARROW(MCK_R_NARROW),
    .CH_WIDE(CH_WIDE), .CH_NARROW(CH_NARROW)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .wrap_i(wrap), .pre_hi_nxt_i(pre_hi_nxt),
    .mck_en_i(act.mck_en), .ch32_i(act.ch32),
    .bck_nxt_o(bck_nxt), .ws_nxt_o(ws_nxt), .frame_end_o(frame_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mck_q <= 1'b0;
      bck_q <= 1'b0;
      ws_q  <= 1'b0;
    end else begin
      mck_q <= act.mck_en & pre_hi_nxt;
      bck_q <= master_i & bck_nxt;
      ws_q  <= master_i & ws_nxt;
    end
  end

  assign mck_o = mck_q;
  assign bck_o = bck_q;
  assign ws_o  = ws_q;

  // R8: slave mode silences bit clock and word select
  assert_slave_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |=> (!bck_o && !ws_o));

  // R5: word select moves only together with a bit-clock falling edge
  assert_ws_on_bck_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ws_o != $past(ws_o)) && $past(master_i) && $past(master_i, 2)) |-> ($past(bck_o) && !bck_o));

  // R4: bit-clock falls line up with master-clock falls
  assert_bck_on_mck_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(bck_o) && $past(master_i) && $past(master_i, 2) &&
     $past(act.mck_en) && $past(act.mck_en, 2)) |-> $fell(mck_o));
endmodule

// File: tb/audio_clkgen_tb_top.sv
module audio_clkgen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;
  localparam int LIM        = 5000;
  localparam int NV         = 5;
  // div, odd, mck_en, ch32, bck_lo, bck_hi, mck_lo, mck_hi, ws_lo_len
  localparam int VEC [NV][9] = '{
    '{2, 0, 0, 0,  2,  2, 0, 0,  64},
    '{3, 1, 0, 1,  3,  4, 0, 0, 224},
    '{2, 1, 1, 1, 10, 10, 2, 3, 640},
    '{3, 0, 1, 0, 24, 24, 3, 3, 768},
    '{5, 1, 0, 0,  5,  6, 0, 0, 176}
  };

  logic       clk, rst_n, master, we, odd, mck_en, ch32;
  logic [7:0] div;
  logic       mck, bck, ws;
  int         checks = 0;
  int         fails  = 0;

  audio_clkgen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master), .cfg_we_i(we),
    .cfg_div_i(div), .cfg_odd_i(odd), .cfg_mck_en_i(mck_en), .cfg_ch32_i(ch32),
    .mck_o(mck), .bck_o(bck), .ws_o(ws)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input int d, input int o, input int m, input int c);
    @(negedge clk);
    we = 1'b1; div = 8'(d); odd = 1'(o); mck_en = 1'(m); ch32 = 1'(c);
    @(negedge clk);
    we = 1'b0;
  endtask

  // Waits for a fresh frame start, then measures the first bit-clock and
  // master-clock phases and the length of the left channel.
  task automatic measure(input string tag, input int bl_e, input int bh_e,
                         input int mck_on, input int ml_e, input int mh_e, input int wl_e);
    int g = 0;
    int bl = 0, bh = 0, ml = 0, mh = 0, wl = 0, bs = 0, ms = 0;
    while (ws !== 1'b1 && g < LIM) begin @(negedge clk); g++; end
    while (ws !== 1'b0 && g < 2 * LIM) begin @(negedge clk); g++; end
    while (ws === 1'b0 && wl < LIM) begin
      wl++;
      if (bs == 0) begin if (!bck) bl++; else begin bs = 1; bh = 1; end end
      else if (bs == 1) begin if (bck) bh++; else bs = 2; end
      if (ms == 0) begin if (!mck) ml++; else begin ms = 1; mh = 1; end end
      else if (ms == 1) begin if (mck) mh++; else ms = 2; end
      @(negedge clk);
    end
    check({tag, " bck low phase"}, bl, bl_e);
    check({tag, " bck high phase"}, bh, bh_e);
    check({tag, " R5 left channel length"}, wl, wl_e);
    if (mck_on != 0) begin
      check({tag, " R4 mck low phase"}, ml, ml_e);
      check({tag, " R4 mck high phase"}, mh, mh_e);
    end else begin
      check({tag, " R3 mck held low"}, mh, 0);
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog (R1..all) actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; master = 1'b1; we = 1'b0; div = 8'd2; odd = 1'b0; mck_en = 1'b0; ch32 = 1'b0;
    repeat (4) @(negedge clk);
    // R1: outputs low under reset
    check("R1 mck in reset", int'(mck), 0);
    check("R1 bck in reset", int'(bck), 0);
    check("R1 ws in reset", int'(ws), 0);
    rst_n = 1'b1;
    // R1: default settings (div 2, odd 0, no mck, 16-bit channels)
    measure("R1 R2 default", 2, 2, 0, 0, 0, 64);

    // R2 R3 R4 R5 R6: table of settings, each applied at a frame start
    for (int v = 0; v < NV; v++) begin
      write_cfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      measure($sformatf("R2 R6 vec%0d", v), VEC[v][4], VEC[v][5], VEC[v][2],
              VEC[v][6], VEC[v][7], VEC[v][8]);
    end

    // R6: mid-frame write keeps old timing until the next frame start
    while (ws !== 1'b1) @(negedge clk);
    while (ws !== 1'b0) @(negedge clk);
    write_cfg(2, 0, 0, 0);
    begin
      int h = 0;
      while (bck !== 1'b1) @(negedge clk);
      while (bck === 1'b1 && h < LIM) begin h++; @(negedge clk); end
      check("R6 old high phase kept mid-frame", h, 6);
    end
    measure("R6 new settings after frame", 2, 2, 0, 0, 0, 64);

    // R7: divide value 1 rejected, settings unchanged
    write_cfg(1, 1, 1, 1);
    measure("R7 illegal divide ignored", 2, 2, 0, 0, 0, 64);

    // R8: slave mode holds bck and ws low
    @(negedge clk);
    master = 1'b0;
    @(negedge clk);
    @(negedge clk);
    begin
      int bh = 0, wh = 0;
      for (int i = 0; i < 200; i++) begin
        if (bck) bh++;
        if (ws) wh++;
        @(negedge clk);
      end
      check("R8 bck high cycles in slave", bh, 0);
      check("R8 ws high cycles in slave", wh, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule